// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the architectural registers of a 32-bit RISC core whose register numbers are remapped by the current processor mode. A 4-bit register number on each of two read ports and one write port is steered to one of 30 physical general-purpose registers, according to a 5-bit mode code supplied alongside. The fast-interrupt mode has private copies of r8 through r14. Every other exception mode has private copies of r13 (stack pointer) and r14 (link register) only. User mode, system mode and any unrecognised code share a single set.

Register 15 is the program counter. It is one register common to all modes. It has its own increment path and is loaded by a general write to register 15. The block also keeps the current status word, which holds the condition flags, a sticky saturation flag, the interrupt masks, the instruction-state bits and the mode field. It keeps one saved status word for each of the five exception modes. The decoder, ALU and exception sequencer sit outside and drive this block through its ports.

Top module: `rbf_top`

## Requirements
- R1: While reset is active and after its release: every general register reads 0, the program counter is 0, the saved status words read 0 and the current status word reads 0x000000D3 (supervisor mode, both interrupt masks set).
- R2: Mode codes are 10000 user, 10001 fast interrupt, 10010 interrupt, 10011 supervisor, 10111 abort, 11011 undefined and 11111 system. User, system and every other code reach one common copy of r0 to r14.
- R3: In fast-interrupt mode, r8 to r14 reach copies private to that mode, and r0 to r7 reach the common copies.
- R4: Interrupt, supervisor, abort and undefined modes each reach a private r13 and r14. All their other registers reach the common copies.
- R5: Reading register 15 on either port returns the program counter in every mode. A write to register 15 loads the program counter and wins over an increment requested in the same cycle. An increment alone adds 4.
- R6: Reads are combinational in the present mode. A register write is stored in the bank selected by the mode code present at the clock edge that performs it, even when the code changes on that same edge.
- R7: Writable status bits are 31 (N), 30 (Z), 29 (C), 28 (V), 27 (Q), 24 (J), 7 (IRQ mask), 6 (fast-interrupt mask), 5 (compact-instruction state) and 4:0 (mode). All other bits of both status words read 0.
- R8: A saturation pulse sets bit 27 of the current status word. The bit then stays at 1 until a status write clears it. A saturation pulse in the same cycle as a write of 0 leaves the bit at 1.
- R9: Each of the five exception modes reads and writes its own saved status word, under the same writable-bit mask as R7.
- R10: In user, system or an unrecognised mode, a saved-status write changes nothing and a saved-status read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 5 | Present processor mode code, selects the bank |
| rd_a_addr | input | 4 | Read port A register number |
| rd_a_data | output | 32 | Read port A data |
| rd_b_addr | input | 4 | Read port B register number |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 4 | Register write number (15 loads the program counter) |
| wr_data | input | 32 | Register write data |
| pc_inc | input | 1 | Advance the program counter by one step |
| pc_o | output | 32 | Program counter |
| st_wr_en | input | 1 | Current status write enable |
| st_wr_data | input | 32 | Current status write data |
| sat_set | input | 1 | Saturation indication, sets the sticky flag |
| st_rd_data | output | 32 | Current status word |
| sv_wr_en | input | 1 | Saved status write enable for the present mode |
| sv_wr_data | input | 32 | Saved status write data |
| sv_rd_data | output | 32 | Saved status word of the present mode |

## Verification
The bench builds the block with its default 32-bit data width and a program-counter step of 4. At these values the complete 30-register physical map and all five saved words can be walked exhaustively, and the register-15 load-over-increment case gives exact addresses. Writes made in every mode followed by reads in every other mode expose any aliasing between banks. Mode changes on the same edge as a write, random status traffic mixed with saturation pulses, and the unrecognised mode code 00000 reach the corner cases of R6, R8 and R10.

// File: rtl/rbf_pkg.sv
package rbf_pkg;

  localparam int XLEN      = 32;
  localparam int MODE_W    = 5;
  localparam int RADDR_W   = 4;

  // physical general register counts
  localparam int COMMON_CNT = 15;                 // r0..r14 shared copy
  localparam int FAST_CNT   = 7;                  // r8..r14 private to fast irq
  localparam int PAIR_CNT   = 2;                  // r13,r14 per other exception mode
  localparam int PAIR_MODES = 4;
  localparam int NUM_GPR    = COMMON_CNT + FAST_CNT + PAIR_CNT * PAIR_MODES;
  localparam int PHYS_W     = $clog2(NUM_GPR);
  localparam int NUM_SAVED  = 1 + PAIR_MODES;
  localparam int FAST_FIRST = 8;
  localparam int PAIR_FIRST = 13;
  localparam logic [RADDR_W-1:0] PC_ADDR = 4'hF;

  // status word layout
  localparam int Q_BIT = 27;
  localparam logic [XLEN-1:0] ST_MASK  = 32'hF900_00FF;
  localparam logic [XLEN-1:0] ST_RESET = 32'h0000_00D3;

  typedef enum logic [MODE_W-1:0] {
    MODE_USR  = 5'b10000,
    MODE_FAST = 5'b10001,
    MODE_IRQ  = 5'b10010,
    MODE_SVC  = 5'b10011,
    MODE_ABT  = 5'b10111,
    MODE_UND  = 5'b11011,
    MODE_SYS  = 5'b11111
  } mode_e;

  typedef enum logic [2:0] {
    BK_COMMON = 3'd0,
    BK_FAST   = 3'd1,
    BK_IRQ    = 3'd2,
    BK_SVC    = 3'd3,
    BK_ABT    = 3'd4,
    BK_UND    = 3'd5
  } bank_e;

  function automatic bank_e bank_of(input logic [MODE_W-1:0] code);
    case (code)
      MODE_FAST: bank_of = BK_FAST;
      MODE_IRQ:  bank_of = BK_IRQ;
      MODE_SVC:  bank_of = BK_SVC;
      MODE_ABT:  bank_of = BK_ABT;
      MODE_UND:  bank_of = BK_UND;
      default:   bank_of = BK_COMMON;
    endcase
  endfunction

endpackage

// File: rtl/rbf_bank_map.sv
module rbf_bank_map
  import rbf_pkg::*;
(
  input  bank_e                     bank,
  input  logic [RADDR_W-1:0]        arch,
  output logic [PHYS_W-1:0]         phys
);

  // layout: 0..14 common, 15..21 fast r8..r14, 22..29 pairs r13/r14
  localparam int FAST_BASE = COMMON_CNT;
  localparam int PAIR_BASE = COMMON_CNT + FAST_CNT;

  always_comb begin
    phys = PHYS_W'(arch);
    if (bank == BK_FAST && int'(arch) >= FAST_FIRST) begin
      phys = PHYS_W'(FAST_BASE + int'(arch) - FAST_FIRST);
    end else if (bank != BK_COMMON && bank != BK_FAST && int'(arch) >= PAIR_FIRST) begin
      phys = PHYS_W'(PAIR_BASE + PAIR_CNT * (int'(bank) - int'(BK_IRQ))
                     + int'(arch) - PAIR_FIRST);
    end
  end

endmodule

// File: rtl/rbf_gpr_store.sv
module rbf_gpr_store
  import rbf_pkg::*;
#(
  parameter int DATA_W = XLEN,
  parameter int DEPTH  = NUM_GPR,
  parameter int NRD    = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we,
  input  logic [PHYS_W-1:0]            waddr,
  input  logic [DATA_W-1:0]            wdata,
  input  logic [NRD-1:0][PHYS_W-1:0]   raddr,
  output logic [NRD-1:0][DATA_W-1:0]   rdata
);

  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    logic en;
    assign en = we && (waddr == PHYS_W'(e));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  mem_q[e] <= '0;
      else if (en) mem_q[e] <= wdata;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p] = mem_q[raddr[p]];
  end

endmodule

// File: rtl/rbf_status.sv
module rbf_status
  import rbf_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  bank_e           bank,
  input  logic            st_wr_en,
  input  logic [XLEN-1:0] st_wr_data,
  input  logic            sat_set,
  output logic [XLEN-1:0] st_q,
  input  logic            sv_wr_en,
  input  logic [XLEN-1:0] sv_wr_data,
  output logic [XLEN-1:0] sv_rd
);

  logic [XLEN-1:0] cur_d;
  logic            cur_en;

  always_comb begin
    cur_d  = st_q;
    cur_en = st_wr_en | sat_set;
    if (st_wr_en) cur_d = st_wr_data & ST_MASK;
    if (sat_set)  cur_d[Q_BIT] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      st_q <= ST_RESET;
    else if (cur_en) st_q <= cur_d;
  end

  logic [XLEN-1:0] sv_q [NUM_SAVED];

  for (genvar s = 0; s < NUM_SAVED; s++) begin : g_saved
    logic en;
    assign en = sv_wr_en && (bank == bank_e'(3'(s + 1)));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  sv_q[s] <= '0;
      else if (en) sv_q[s] <= sv_wr_data & ST_MASK;
    end
  end

  logic [2:0] sidx;
  assign sidx  = 3'(bank) - 3'd1;
  assign sv_rd = (bank == BK_COMMON) ? '0 : sv_q[sidx];

endmodule

// File: rtl/rbf_top.sv
module rbf_top
  import rbf_pkg::*;
#(
  parameter int DATA_W  = XLEN,
  parameter int PC_STEP = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [MODE_W-1:0]   mode_i,
  input  logic [RADDR_W-1:0]  rd_a_addr,
  output logic [DATA_W-1:0]   rd_a_data,
  input  logic [RADDR_W-1:0]  rd_b_addr,
  output logic [DATA_W-1:0]   rd_b_data,
  input  logic                wr_en,
  input  logic [RADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                pc_inc,
  output logic [DATA_W-1:0]   pc_o,
  input  logic                st_wr_en,
  input  logic [DATA_W-1:0]   st_wr_data,
  input  logic                sat_set,
  output logic [DATA_W-1:0]   st_rd_data,
  input  logic                sv_wr_en,
  input  logic [DATA_W-1:0]   sv_wr_data,
  output logic [DATA_W-1:0]   sv_rd_data
);

  localparam int NRD = 2;

  bank_e bank;
  assign bank = bank_of(mode_i);

  // ---- read address remap ----
  logic [NRD-1:0][RADDR_W-1:0] rd_arch;
  logic [NRD-1:0][PHYS_W-1:0]  rd_phys;
  logic [NRD-1:0][DATA_W-1:0]  rd_raw;
  logic [NRD-1:0][DATA_W-1:0]  rd_out;

  assign rd_arch[0] = rd_a_addr;
  assign rd_arch[1] = rd_b_addr;

  for (genvar p = 0; p < NRD; p++) begin : g_rmap
    rbf_bank_map u_map (
      .bank (bank),
      .arch (rd_arch[p]),
      .phys (rd_phys[p])
    );
    assign rd_out[p] = (rd_arch[p] == PC_ADDR) ? pc_o : rd_raw[p];
  end

  assign rd_a_data = rd_out[0];
  assign rd_b_data = rd_out[1];

  // ---- write address remap ----
  logic [PHYS_W-1:0] wr_phys;
  logic              gpr_we;
  logic              pc_ld;

  assign pc_ld  = wr_en && (wr_addr == PC_ADDR);
  assign gpr_we = wr_en && !pc_ld;

  rbf_bank_map u_wmap (
    .bank (bank),
    .arch (wr_addr),
    .phys (wr_phys)
  );

  rbf_gpr_store #(
    .DATA_W (DATA_W),
    .DEPTH  (NUM_GPR),
    .NRD    (NRD)
  ) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (gpr_we),
    .waddr (wr_phys),
    .wdata (wr_data),
    .raddr (rd_phys),
    .rdata (rd_raw)
  );

  // ---- program counter ----
  logic [DATA_W-1:0] pc_d;
  logic              pc_en;

  always_comb begin
    pc_en = pc_ld | pc_inc;
    pc_d  = pc_o + DATA_W'(PC_STEP);
    if (pc_ld) pc_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_o <= '0;
    else if (pc_en) pc_o <= pc_d;
  end

  // ---- status words ----
  rbf_status u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .bank       (bank),
    .st_wr_en   (st_wr_en),
    .st_wr_data (st_wr_data),
    .sat_set    (sat_set),
    .st_q       (st_rd_data),
    .sv_wr_en   (sv_wr_en),
    .sv_wr_data (sv_wr_data),
    .sv_rd      (sv_rd_data)
  );

endmodule

// File: rtl/rbf_top_chk.sv
module rbf_top_chk
  import rbf_pkg::*;
#(
  parameter int PC_STEP = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [MODE_W-1:0]  mode_i,
  input logic [RADDR_W-1:0] rd_a_addr,
  input logic [XLEN-1:0]    rd_a_data,
  input logic               wr_en,
  input logic [RADDR_W-1:0] wr_addr,
  input logic [XLEN-1:0]    wr_data,
  input logic               pc_inc,
  input logic [XLEN-1:0]    pc_o,
  input logic               st_wr_en,
  input logic               sat_set,
  input logic [XLEN-1:0]    st_rd_data,
  input logic               sv_wr_en,
  input logic [XLEN-1:0]    sv_rd_data
);

  AST_PC_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == PC_ADDR) |=> pc_o == $past(wr_data)); // R5

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && wr_addr == PC_ADDR) && pc_inc) |=> pc_o == $past(pc_o) + XLEN'(PC_STEP)); // R5

  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !pc_inc) |=> $stable(pc_o)); // R5

  AST_GPR_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != PC_ADDR) |=>
      (mode_i != $past(mode_i) || rd_a_addr != $past(wr_addr) || rd_a_data == $past(wr_data))); // R6

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_rd_data & ~ST_MASK) == '0) && ((sv_rd_data & ~ST_MASK) == '0)); // R7

  AST_SAT_SETS_Q: assert property (@(posedge clk) disable iff (!rst_n)
    sat_set |=> st_rd_data[Q_BIT]); // R8

  AST_Q_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_rd_data[Q_BIT] && !st_wr_en) |=> st_rd_data[Q_BIT]); // R8

  AST_SAVED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sv_wr_en && bank_of(mode_i) != BK_COMMON) |=>
      (mode_i != $past(mode_i) || sv_rd_data == $past(sv_rd_data))); // R9

  AST_SAVED_ABSENT: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_of(mode_i) == BK_COMMON) |-> sv_rd_data == '0); // R10

endmodule

bind rbf_top rbf_top_chk #(.PC_STEP(PC_STEP)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_i     (mode_i),
  .rd_a_addr  (rd_a_addr),
  .rd_a_data  (rd_a_data),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .pc_inc     (pc_inc),
  .pc_o       (pc_o),
  .st_wr_en   (st_wr_en),
  .sat_set    (sat_set),
  .st_rd_data (st_rd_data),
  .sv_wr_en   (sv_wr_en),
  .sv_rd_data (sv_rd_data)
);

// File: tb/rbf_top_tb.sv
`timescale 1ns/1ps
module rbf_top_tb;

  logic        clk, rst_n;
  logic [4:0]  mode_i;
  logic [3:0]  rd_a_addr, rd_b_addr, wr_addr;
  logic [31:0] rd_a_data, rd_b_data, wr_data, pc_o;
  logic        wr_en, pc_inc, st_wr_en, sat_set, sv_wr_en;
  logic [31:0] st_wr_data, st_rd_data, sv_wr_data, sv_rd_data;

  rbf_top u_dut (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int vectors = 0;
  int fails   = 0;

  // staged stimulus, applied just after a falling edge
  logic [4:0]  s_mode;
  logic [3:0]  s_ra, s_rb, s_wa;
  logic [31:0] s_wd, s_sd, s_vd;
  logic        s_we, s_inc, s_swe, s_sat, s_vwe;

  // behavioural reference: one view of r0..r14 per mode index
  logic [31:0] ref_gpr [0:6][0:14];
  logic [31:0] ref_pc, ref_st;
  logic [31:0] ref_sv [0:6];
  localparam logic [31:0] MASK = 32'hF900_00FF;
  localparam logic [4:0] CODES [0:7] =
    '{5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F, 5'h00};

  // 0 user,1 fast,2 irq,3 svc,4 abt,5 und,6 system; unknown -> user
  function automatic int midx(input logic [4:0] c);
    case (c)
      5'h11: return 1;
      5'h12: return 2;
      5'h13: return 3;
      5'h17: return 4;
      5'h1B: return 5;
      5'h1F: return 6;
      default: return 0;
    endcase
  endfunction

  function automatic bit shared(input int a, input int b, input int r);
    if (r < 8)  return 1'b1;
    if (r < 13) return (a == 1) == (b == 1);
    return (a == b) || ((a == 0 || a == 6) && (b == 0 || b == 6));
  endfunction

  function automatic string rtag(input int m, input int r);
    if (r == 15)            return "R5";
    if (m == 1 && r >= 8)   return "R3";
    if (m >= 2 && m <= 5 && r >= 13) return "R4";
    return "R2";
  endfunction

  function automatic logic [31:0] ref_rd(input int m, input int r);
    return (r == 15) ? ref_pc : ref_gpr[m][r];
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic model_reset();
    for (int m = 0; m < 7; m++) begin
      ref_sv[m] = '0;
      for (int r = 0; r < 15; r++) ref_gpr[m][r] = '0;
    end
    ref_pc = '0;
    ref_st = 32'h0000_00D3;
  endtask

  task automatic idle_stage();
    s_we = 0; s_inc = 0; s_swe = 0; s_sat = 0; s_vwe = 0;
    s_wa = 0; s_wd = 0; s_sd = 0; s_vd = 0;
  endtask

  // one clock: apply, compare combinational outputs, advance the model
  task automatic do_cycle();
    int m;
    logic [31:0] st_n;
    @(negedge clk);
    mode_i = s_mode; rd_a_addr = s_ra; rd_b_addr = s_rb;
    wr_en = s_we; wr_addr = s_wa; wr_data = s_wd; pc_inc = s_inc;
    st_wr_en = s_swe; st_wr_data = s_sd; sat_set = s_sat;
    sv_wr_en = s_vwe; sv_wr_data = s_vd;
    #1;
    m = midx(s_mode);
    chk(rtag(m, int'(s_ra)), "port A", rd_a_data, ref_rd(m, int'(s_ra)));
    chk(rtag(m, int'(s_rb)), "port B", rd_b_data, ref_rd(m, int'(s_rb)));
    chk("R5", "pc", pc_o, ref_pc);
    chk("R7/R8", "status", st_rd_data, ref_st);
    chk((m >= 1 && m <= 5) ? "R9" : "R10", "saved", sv_rd_data,
        (m >= 1 && m <= 5) ? ref_sv[m] : 32'h0);
    // next state, mode sampled at this edge (R6)
    if (s_we && s_wa == 4'hF) ref_pc = s_wd;
    else if (s_inc)            ref_pc = ref_pc + 32'd4;
    if (s_we && s_wa != 4'hF)
      for (int k = 0; k < 7; k++)
        if (shared(m, k, int'(s_wa))) ref_gpr[k][s_wa] = s_wd;
    st_n = s_swe ? (s_sd & MASK) : ref_st;
    if (s_sat) st_n[27] = 1'b1;
    ref_st = st_n;
    if (s_vwe && m >= 1 && m <= 5) ref_sv[m] = s_vd & MASK;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    rst_n = 0;
    mode_i = 5'h10; rd_a_addr = 0; rd_b_addr = 0; wr_en = 0; wr_addr = 0;
    wr_data = 0; pc_inc = 0; st_wr_en = 0; st_wr_data = 0; sat_set = 0;
    sv_wr_en = 0; sv_wr_data = 0;
    s_mode = 5'h10; s_ra = 0; s_rb = 0;
    idle_stage();
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "status in reset", st_rd_data, 32'h0000_00D3);
    chk("R1", "pc in reset", pc_o, 32'h0);
    @(negedge clk);
    rst_n = 1;

    // R1: every register of every bank reads zero after release
    for (int c = 0; c < 8; c++)
      for (int r = 0; r < 16; r++) begin
        s_mode = CODES[c]; s_ra = 4'(r); s_rb = 4'(15 - r);
        do_cycle();
      end

    // R2 R3 R4: fill every bank with a distinct value, then cross-read
    for (int c = 0; c < 7; c++)
      for (int r = 0; r < 15; r++) begin
        idle_stage();
        s_mode = CODES[c]; s_we = 1; s_wa = 4'(r);
        s_wd = {8'hA0 + 8'(c), 16'h0, 8'(r)};
        s_ra = 4'(r); s_rb = 4'((r + 1) % 16);
        do_cycle();
      end
    idle_stage();
    for (int c = 0; c < 8; c++)
      for (int r = 0; r < 16; r++) begin
        s_mode = CODES[c]; s_ra = 4'(r); s_rb = 4'(14 - (r % 15));
        do_cycle();
      end

    // R6: write r13 in user while the mode turns to irq on the same edge
    idle_stage();
    s_mode = 5'h10; s_we = 1; s_wa = 4'd13; s_wd = 32'h1357_9BDF; s_ra = 4'd13;
    do_cycle();
    idle_stage(); s_mode = 5'h12; do_cycle();
    idle_stage(); s_mode = 5'h10; do_cycle();
    s_mode = 5'h1F; do_cycle();

    // R5: increment, then load over a simultaneous increment
    idle_stage(); s_ra = 4'hF; s_rb = 4'hF;
    s_inc = 1; repeat (3) do_cycle();
    s_we = 1; s_wa = 4'hF; s_wd = 32'h0000_8000; do_cycle();
    s_we = 0; do_cycle();
    s_inc = 0; do_cycle();

    // R7 R8: full write masked, sticky flag behaviour
    idle_stage(); s_mode = 5'h13;
    s_swe = 1; s_sd = 32'hFFFF_FFFF; do_cycle();
    s_swe = 1; s_sd = 32'h0; do_cycle();
    s_swe = 0; s_sat = 1; do_cycle();
    s_sat = 0; repeat (2) do_cycle();
    s_swe = 1; s_sd = 32'h0; s_sat = 1; do_cycle();
    s_swe = 1; s_sat = 0; do_cycle();
    s_swe = 0; do_cycle();

    // R9 R10: saved words per mode, ignored in user/system/unknown
    for (int c = 0; c < 8; c++) begin
      idle_stage(); s_mode = CODES[c]; s_vwe = 1; s_vd = 32'hFFFF_FF00 | 32'(c);
      do_cycle();
    end
    idle_stage();
    for (int c = 0; c < 8; c++) begin s_mode = CODES[c]; do_cycle(); end

    // random mix
    for (int i = 0; i < 4000; i++) begin
      s_mode = CODES[$urandom_range(0, 7)];
      s_ra = 4'($urandom); s_rb = 4'($urandom);
      s_we = ($urandom_range(0, 3) != 0);
      s_wa = ($urandom_range(0, 15) == 0) ? 4'hF : 4'($urandom_range(0, 14));
      s_wd = $urandom; s_inc = $urandom_range(0, 1) == 1;
      s_swe = ($urandom_range(0, 7) == 0); s_sd = $urandom;
      s_sat = ($urandom_range(0, 9) == 0);
      s_vwe = ($urandom_range(0, 3) == 0); s_vd = $urandom;
      do_cycle();
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule